// File: doc/BRIEF.md
# Interrupt Status Queue Writer

This block turns interrupt events into two-word records in a circular queue held in shared RAM. Each record holds a vector word and a parameter word. The vector word says what kind of event occurred. The parameter word carries the data that belongs to that event. The block owns the write port into the queue region and the running queue pointer. It signals the host through a one-cycle interrupt request after each record. A separate rollover interrupt fires when the pointer wraps around the 64-word queue region.

Two kinds of event feed the block. The first is the message event, which carries the address of the block status word of a command stack descriptor and some status bits. The second is a set of four non-message conditions: RAM parity failure, which carries the failing address; RT address parity failure; time tag counter rollover; and self-test completion. Every event is a single-cycle pulse. The block holds pending events until it can store them and writes them one record at a time in a fixed priority order. Upper base-address bits select which 64-word region of RAM the queue lives in.

Top module: `isq_writer`

## Requirements
- R1: A record is two RAM writes in consecutive cycles. The vector word goes to an even queue offset and the parameter word goes to the next address.
- R2: A message record has vector bit 0 set, vector bits 4:1 clear, and `msg_evt_status` in vector bits 15:5. Its parameter word is `msg_evt_ptr`.
- R3: A non-message record has vector bit 0 clear and exactly one of bits 4:1 set: bit 1 for RAM parity, bit 2 for RT address parity, bit 3 for time tag rollover, and bit 4 for self-test complete. Bits 15:5 are zero.
- R4: A RAM parity record's parameter word is the failing address given with the event. For RT address parity, time tag rollover and self-test complete, the parameter word is 0x0000.
- R5: When several events are pending, records are written in this order: RAM parity, RT address parity, time tag rollover, self-test complete, message.
- R6: The queue pointer resets to offset 0 and steps by 2 per record, modulo 64. Its upper bits come from `base_addr[15:6]`; `base_addr[5:0]` has no effect.
- R7: `irq_pulse` is high for exactly one cycle, in the cycle after each parameter word is written.
- R8: `rollover_irq` pulses together with `irq_pulse` for the record written at offset 62, and only if `rollover_en` was high.
- R9: With the writer idle, an event sampled at clock edge n produces its vector write in the cycle after edge n+1. Pending records follow one another with no idle cycle in between.
- R10: Events that arrive while `queue_en` is low are discarded, and no record is ever written for them.
- R11: An event of a type that is still pending merges with the pending one. Only one record is written, and it keeps the first event's parameter.
- R12: After reset, `ram_we`, `irq_pulse` and `rollover_irq` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| queue_en | input | 1 | Accept new events when high |
| rollover_en | input | 1 | Allow the wrap interrupt |
| base_addr | input | 16 | Queue region select; bits 15:6 are used |
| msg_evt | input | 1 | Message event pulse |
| msg_evt_ptr | input | 16 | Descriptor block status word address |
| msg_evt_status | input | 11 | Extra message status for vector bits 15:5 |
| ram_par_evt | input | 1 | RAM parity failure pulse |
| ram_par_addr | input | 16 | Failing RAM address |
| rt_par_evt | input | 1 | RT address parity failure pulse |
| tt_roll_evt | input | 1 | Time tag rollover pulse |
| bist_done_evt | input | 1 | Self-test complete pulse |
| ram_we | output | 1 | Queue RAM write strobe |
| ram_addr | output | 16 | Queue RAM write address |
| ram_wdata | output | 16 | Queue RAM write data |
| queue_ptr | output | 16 | Address of the next record |
| irq_pulse | output | 1 | Record-written interrupt |
| rollover_irq | output | 1 | Queue wrap interrupt |

## Verification
The bound checker checks these properties on every cycle:
- each vector write is followed by its parameter write at the next address;
- the vector word's type field is consistent, with either bit 0 or a single code bit set;
- the parameter word is zero for code-only events;
- the request pulse follows every parameter write and lasts one cycle;
- the pointer steps by two with each request;
- a rollover always coincides with a request, happens at offset zero, and is gated by its enable.

Other behaviours depend on the stimulus history, so only the directed scenarios can show them:
- the priority order among simultaneous events;
- the exact latency from an event pulse to its writes;
- the merging of repeated events;
- the discarding of events while the queue is disabled;
- whether the rollover appears exactly once per lap.

// File: rtl/isq_pkg.sv
// Package: shared constants and state type for the interrupt status queue writer.
// Assumes event slot indices double as priority: a lower index wins.
package isq_pkg;
    localparam int NUM_EVT   = 5;
    localparam int IX_RAMPAR = 0;
    localparam int IX_RTPAR  = 1;
    localparam int IX_TTROLL = 2;
    localparam int IX_BIST   = 3;
    localparam int IX_MSG    = 4;

    // Position and width of the one-hot non-message code inside the vector word
    localparam int CODE_LSB  = 1;
    localparam int CODE_W    = 4;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_VEC  = 2'd1,
        ST_PAR  = 2'd2
    } isq_state_e;
endpackage

// File: rtl/isq_event_hold.sv
// Module: isq_event_hold
// Holds one pending flag per event type, along with the parameters that
// come with RAM parity and message events. While a flag is set, a repeat of
// the same type merges into it and the first parameter is kept. If an event
// arrives in the same cycle as the grant of its type, it starts a fresh
// pending entry. Assumes event inputs are single-cycle pulses.
module isq_event_hold
    import isq_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int STAT_W = 11
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               capture_en,
    input  logic [NUM_EVT-1:0] evt_hit,
    input  logic [NUM_EVT-1:0] grant,
    input  logic [ADDR_W-1:0]  par_addr_in,
    input  logic [ADDR_W-1:0]  msg_ptr_in,
    input  logic [STAT_W-1:0]  msg_stat_in,
    output logic [NUM_EVT-1:0] pending,
    output logic [ADDR_W-1:0]  held_par_addr,
    output logic [ADDR_W-1:0]  held_msg_ptr,
    output logic [STAT_W-1:0]  held_msg_stat
);
    logic [NUM_EVT-1:0] accept;
    logic [NUM_EVT-1:0] slot_free;

    // Gate new events with the enable and work out which slots can take a new parameter
    always_comb begin
        accept    = evt_hit & {NUM_EVT{capture_en}};
        slot_free = ~pending | grant;
    end

    generate
        for (genvar g = 0; g < NUM_EVT; g++) begin : g_flag
            // A slot is cleared when granted and set again by a new accepted event
            always_ff @(posedge clk) begin
                if (!rst_n) pending[g] <= 1'b0;
                else        pending[g] <= (pending[g] & ~grant[g]) | accept[g];
            end
        end
    endgenerate

    // Record the failing RAM address only when the slot takes a fresh event
    always_ff @(posedge clk) begin
        if (!rst_n)                                      held_par_addr <= '0;
        else if (accept[IX_RAMPAR] && slot_free[IX_RAMPAR]) held_par_addr <= par_addr_in;
    end

    // Record the message pointer and status only when the slot takes a fresh event
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            held_msg_ptr  <= '0;
            held_msg_stat <= '0;
        end else if (accept[IX_MSG] && slot_free[IX_MSG]) begin
            held_msg_ptr  <= msg_ptr_in;
            held_msg_stat <= msg_stat_in;
        end
    end
endmodule

// File: rtl/isq_priority_pick.sv
// Module: isq_priority_pick
// Fixed-priority one-hot selector: the lowest set request index wins.
// Purely combinational.
module isq_priority_pick
    import isq_pkg::*;
(
    input  logic [NUM_EVT-1:0] req,
    output logic [NUM_EVT-1:0] pick,
    output logic               any
);
    // Walk from highest to lowest index so the lowest set index ends up chosen
    always_comb begin
        pick = '0;
        for (int i = NUM_EVT - 1; i >= 0; i--) begin
            if (req[i]) pick = NUM_EVT'(1) << i;
        end
        any = |req;
    end
endmodule

// File: rtl/isq_entry_build.sv
// Module: isq_entry_build
// Builds the vector and parameter words for the granted event.
// Message: bit 0 set, status in the bits above the code field, parameter = pointer.
// Non-message: one-hot code, parameter = failing address for RAM parity, else zero.
// Assumes grant is one-hot or zero and ADDR_W <= DATA_W.
module isq_entry_build
    import isq_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 16,
    parameter int STAT_W = 11
) (
    input  logic [NUM_EVT-1:0] grant,
    input  logic [ADDR_W-1:0]  held_par_addr,
    input  logic [ADDR_W-1:0]  held_msg_ptr,
    input  logic [STAT_W-1:0]  held_msg_stat,
    output logic [DATA_W-1:0]  vec_word,
    output logic [DATA_W-1:0]  par_word
);
    localparam int STAT_LSB = CODE_LSB + CODE_W;

    // Assemble both words of the record from the grant and the held parameters
    always_comb begin
        vec_word = '0;
        par_word = '0;
        if (grant[IX_MSG]) begin
            vec_word[0]                       = 1'b1;
            vec_word[DATA_W-1:STAT_LSB]       = held_msg_stat;
            par_word                          = DATA_W'(held_msg_ptr);
        end else begin
            for (int k = 0; k < CODE_W; k++) begin
                vec_word[CODE_LSB + k] = grant[k];
            end
            if (grant[IX_RAMPAR]) par_word = DATA_W'(held_par_addr);
        end
    end
endmodule

// File: rtl/isq_queue_ptr.sv
// Module: isq_queue_ptr
// Circular record pointer inside a QWORDS-word aligned region. Only the low
// IDX_W bits count; the region bits come straight from the caller. Assumes
// QWORDS is a power of two and each record occupies two words.
module isq_queue_ptr #(
    parameter int ADDR_W = 16,
    parameter int QWORDS = 64
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    advance,
    input  logic [ADDR_W-1:$clog2(QWORDS)] region,
    output logic [ADDR_W-1:0]       ptr,
    output logic                    at_last
);
    localparam int IDX_W = $clog2(QWORDS);

    logic [IDX_W-1:0] idx_q;

    // Step by one record (two words) per completed entry, wrapping modulo QWORDS
    always_ff @(posedge clk) begin
        if (!rst_n)       idx_q <= '0;
        else if (advance) idx_q <= idx_q + IDX_W'(2);
    end

    // Form the full address and flag the final slot before the wrap
    always_comb begin
        ptr     = {region, idx_q};
        at_last = (idx_q == IDX_W'(QWORDS - 2));
    end
endmodule

// File: rtl/isq_writer.sv
// Module: isq_writer (top)
// Interrupt status queue writer. It captures single-cycle event pulses,
// picks one by fixed priority, and writes a vector word and then a parameter
// word into a circular RAM queue. After each record it pulses an interrupt,
// and it raises a separate interrupt when the pointer wraps. Assumes
// base_addr stays stable while records are being written.
module isq_writer
    import isq_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 16,
    parameter int QWORDS = 64
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                queue_en,
    input  logic                rollover_en,
    input  logic [ADDR_W-1:0]   base_addr,
    input  logic                msg_evt,
    input  logic [ADDR_W-1:0]   msg_evt_ptr,
    input  logic [DATA_W-CODE_LSB-CODE_W-1:0] msg_evt_status,
    input  logic                ram_par_evt,
    input  logic [ADDR_W-1:0]   ram_par_addr,
    input  logic                rt_par_evt,
    input  logic                tt_roll_evt,
    input  logic                bist_done_evt,
    output logic                ram_we,
    output logic [ADDR_W-1:0]   ram_addr,
    output logic [DATA_W-1:0]   ram_wdata,
    output logic [ADDR_W-1:0]   queue_ptr,
    output logic                irq_pulse,
    output logic                rollover_irq
);
    localparam int IDX_W  = $clog2(QWORDS);
    localparam int STAT_W = DATA_W - CODE_LSB - CODE_W;

    isq_state_e         state_q;
    logic [NUM_EVT-1:0] evt_hit;
    logic [NUM_EVT-1:0] pending;
    logic [NUM_EVT-1:0] pick;
    logic [NUM_EVT-1:0] grant;
    logic               any_pending;
    logic               take;
    logic               advance;
    logic               at_last;
    logic [ADDR_W-1:0]  held_par_addr;
    logic [ADDR_W-1:0]  held_msg_ptr;
    logic [STAT_W-1:0]  held_msg_stat;
    logic [DATA_W-1:0]  vec_word;
    logic [DATA_W-1:0]  par_word;
    logic [DATA_W-1:0]  vec_q;
    logic [DATA_W-1:0]  par_q;
    logic               unused_base_low;

    assign unused_base_low = ^base_addr[IDX_W-1:0];

    // Collect the event pulses in priority slot order
    always_comb begin
        evt_hit             = '0;
        evt_hit[IX_RAMPAR]  = ram_par_evt;
        evt_hit[IX_RTPAR]   = rt_par_evt;
        evt_hit[IX_TTROLL]  = tt_roll_evt;
        evt_hit[IX_BIST]    = bist_done_evt;
        evt_hit[IX_MSG]     = msg_evt;
    end

    isq_event_hold #(
        .ADDR_W (ADDR_W),
        .STAT_W (STAT_W)
    ) u_hold (
        .clk           (clk),
        .rst_n         (rst_n),
        .capture_en    (queue_en),
        .evt_hit       (evt_hit),
        .grant         (grant),
        .par_addr_in   (ram_par_addr),
        .msg_ptr_in    (msg_evt_ptr),
        .msg_stat_in   (msg_evt_status),
        .pending       (pending),
        .held_par_addr (held_par_addr),
        .held_msg_ptr  (held_msg_ptr),
        .held_msg_stat (held_msg_stat)
    );

    isq_priority_pick u_pick (
        .req  (pending),
        .pick (pick),
        .any  (any_pending)
    );

    // A new record may start whenever the next cycle is not a parameter write
    always_comb begin
        take    = any_pending && (state_q != ST_VEC);
        grant   = take ? pick : '0;
        advance = (state_q == ST_PAR);
    end

    isq_entry_build #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W),
        .STAT_W (STAT_W)
    ) u_build (
        .grant         (grant),
        .held_par_addr (held_par_addr),
        .held_msg_ptr  (held_msg_ptr),
        .held_msg_stat (held_msg_stat),
        .vec_word      (vec_word),
        .par_word      (par_word)
    );

    isq_queue_ptr #(
        .ADDR_W (ADDR_W),
        .QWORDS (QWORDS)
    ) u_ptr (
        .clk     (clk),
        .rst_n   (rst_n),
        .advance (advance),
        .region  (base_addr[ADDR_W-1:IDX_W]),
        .ptr     (queue_ptr),
        .at_last (at_last)
    );

    // Sequence the two write cycles of each record, chaining straight into the next
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            case (state_q)
                ST_VEC:  state_q <= ST_PAR;
                default: state_q <= take ? ST_VEC : ST_IDLE;
            endcase
        end
    end

    // Freeze the record words at the moment the event is granted
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vec_q <= '0;
            par_q <= '0;
        end else if (take) begin
            vec_q <= vec_word;
            par_q <= par_word;
        end
    end

    // Pulse the request after each record and the rollover on the wrapping record
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_pulse    <= 1'b0;
            rollover_irq <= 1'b0;
        end else begin
            irq_pulse    <= advance;
            rollover_irq <= advance && at_last && rollover_en;
        end
    end

    // Drive the RAM port from the current write phase
    always_comb begin
        ram_we    = (state_q != ST_IDLE);
        ram_addr  = queue_ptr;
        ram_wdata = '0;
        if (state_q == ST_VEC) begin
            ram_wdata = vec_q;
        end else if (state_q == ST_PAR) begin
            ram_addr  = queue_ptr | ADDR_W'(1);
            ram_wdata = par_q;
        end
    end
endmodule

// File: rtl/isq_writer_chk.sv
// Module: isq_writer_chk
// Protocol checker for isq_writer, attached to it by the bind below.
// Watches only the top-level ports.
module isq_writer_chk
    import isq_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 16,
    parameter int QWORDS = 64
) (
    input logic                clk,
    input logic                rst_n,
    input logic                rollover_en,
    input logic                ram_we,
    input logic [ADDR_W-1:0]   ram_addr,
    input logic [DATA_W-1:0]   ram_wdata,
    input logic [ADDR_W-1:0]   queue_ptr,
    input logic                irq_pulse,
    input logic                rollover_irq
);
    localparam int IDX_W = $clog2(QWORDS);

    // R1: a vector write is followed by the parameter write at the next address
    p_entry_pair_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (ram_we && !ram_addr[0]) |=> (ram_we && ram_addr == $past(ram_addr) + ADDR_W'(1)));

    // R3: the vector type field is either the message bit or exactly one code bit
    p_vec_type_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (ram_we && !ram_addr[0]) |->
        (ram_wdata[0] ? (ram_wdata[CODE_LSB+CODE_W-1:CODE_LSB] == '0)
                      : ($countones(ram_wdata[CODE_LSB+CODE_W-1:CODE_LSB]) == 1)));

    // R4: code-only events other than RAM parity carry a zero parameter word
    p_zero_param_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (ram_we && ram_addr[0] && !$past(ram_wdata[0]) && !$past(ram_wdata[CODE_LSB]))
        |-> (ram_wdata == '0));

    // R7: a request follows every parameter write
    p_irq_after_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (ram_we && ram_addr[0]) |=> irq_pulse);

    // R7: the request lasts one cycle
    p_irq_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
        irq_pulse |=> !irq_pulse);

    // R6: each request comes with a two-word pointer step
    p_ptr_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
        irq_pulse |-> (queue_ptr[IDX_W-1:0] == $past(queue_ptr[IDX_W-1:0]) + IDX_W'(2)));

    // R8: a rollover coincides with a request
    p_roll_with_irq_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rollover_irq |-> irq_pulse);

    // R8: a rollover leaves the pointer at offset zero
    p_roll_at_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rollover_irq |-> (queue_ptr[IDX_W-1:0] == '0));

    // R8: a rollover needs the enable
    p_roll_gated_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rollover_irq |-> $past(rollover_en));
endmodule

bind isq_writer isq_writer_chk #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .QWORDS (QWORDS)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .rollover_en  (rollover_en),
    .ram_we       (ram_we),
    .ram_addr     (ram_addr),
    .ram_wdata    (ram_wdata),
    .queue_ptr    (queue_ptr),
    .irq_pulse    (irq_pulse),
    .rollover_irq (rollover_irq)
);

// File: tb/tb_isq_writer.sv
// Directed bench for isq_writer. It drives inputs and samples outputs on the
// falling edge, and the logger records every write and interrupt pulse.
module tb_isq_writer;
    localparam logic [15:0] BASE   = 16'h0315;
    localparam logic [15:0] REGION = 16'h0300;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        queue_en = 1'b0;
    logic        rollover_en = 1'b0;
    logic [15:0] base_addr = BASE;
    logic        msg_evt = 1'b0;
    logic [15:0] msg_evt_ptr = '0;
    logic [10:0] msg_evt_status = '0;
    logic        ram_par_evt = 1'b0;
    logic [15:0] ram_par_addr = '0;
    logic        rt_par_evt = 1'b0;
    logic        tt_roll_evt = 1'b0;
    logic        bist_done_evt = 1'b0;
    logic        ram_we;
    logic [15:0] ram_addr;
    logic [15:0] ram_wdata;
    logic [15:0] queue_ptr;
    logic        irq_pulse;
    logic        rollover_irq;

    always #4 clk = ~clk;

    isq_writer dut (
        .clk(clk), .rst_n(rst_n), .queue_en(queue_en), .rollover_en(rollover_en),
        .base_addr(base_addr), .msg_evt(msg_evt), .msg_evt_ptr(msg_evt_ptr),
        .msg_evt_status(msg_evt_status), .ram_par_evt(ram_par_evt),
        .ram_par_addr(ram_par_addr), .rt_par_evt(rt_par_evt), .tt_roll_evt(tt_roll_evt),
        .bist_done_evt(bist_done_evt), .ram_we(ram_we), .ram_addr(ram_addr),
        .ram_wdata(ram_wdata), .queue_ptr(queue_ptr), .irq_pulse(irq_pulse),
        .rollover_irq(rollover_irq)
    );

    int n_chk = 0;
    int n_bad = 0;
    int cyc = 0;
    int exp_idx = 0;
    bit done = 1'b0;

    logic [15:0] log_addr [0:127];
    logic [15:0] log_data [0:127];
    int          log_cyc  [0:127];
    int          irq_cyc  [0:127];
    int          roll_cyc [0:127];
    int n_log = 0, n_irq = 0, n_roll = 0;
    logic [15:0] exp_vec [0:7];
    logic [15:0] exp_par [0:7];

    always @(posedge clk) cyc <= cyc + 1;

    // Logger: record every write and interrupt pulse at the falling edge
    always @(negedge clk) begin
        if (rst_n) begin
            if (ram_we && n_log < 128) begin
                log_addr[n_log] = ram_addr; log_data[n_log] = ram_wdata;
                log_cyc[n_log] = cyc; n_log++;
            end
            if (irq_pulse && n_irq < 128) begin irq_cyc[n_irq] = cyc; n_irq++; end
            if (rollover_irq && n_roll < 128) begin roll_cyc[n_roll] = cyc; n_roll++; end
        end
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic clr_log();
        n_log = 0; n_irq = 0; n_roll = 0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Compare n logged records against exp_vec/exp_par, then advance the model pointer
    task automatic check_records(input int n, input string req);
        chk(n_log == 2 * n, req, n_log, 2 * n);
        chk(n_irq == n, "R7", n_irq, n);
        for (int j = 0; j < n && 2 * j + 1 < n_log; j++) begin
            logic [15:0] a;
            a = REGION | 16'((exp_idx + 2 * j) % 64);
            chk(log_addr[2*j] == a, "R1", log_addr[2*j], a);
            chk(log_addr[2*j+1] == a + 16'd1, "R1", log_addr[2*j+1], a + 16'd1);
            chk(log_data[2*j] == exp_vec[j], req, log_data[2*j], exp_vec[j]);
            chk(log_data[2*j+1] == exp_par[j], req, log_data[2*j+1], exp_par[j]);
        end
        exp_idx = (exp_idx + 2 * n) % 64;
        chk(queue_ptr == (REGION | 16'(exp_idx)), "R6", queue_ptr, REGION | 16'(exp_idx));
    endtask

    task automatic t_reset();
        idle(2);
        chk(ram_we == 1'b0, "R12", ram_we, 0);
        chk(irq_pulse == 1'b0 && rollover_irq == 1'b0, "R12", {irq_pulse, rollover_irq}, 0);
        chk(queue_ptr == REGION, "R6", queue_ptr, REGION);
    endtask

    // R2, R9: one message, checking both words and the cycle-exact latency
    task automatic t_message();
        int c;
        clr_log();
        @(negedge clk);
        msg_evt = 1'b1; msg_evt_ptr = 16'h1234; msg_evt_status = 11'h5A3; c = cyc;
        @(negedge clk);
        msg_evt = 1'b0;
        idle(6);
        exp_vec[0] = {11'h5A3, 5'b00001}; exp_par[0] = 16'h1234;
        if (n_log >= 2) begin
            chk(log_cyc[0] == c + 2, "R9", log_cyc[0], c + 2);
            chk(log_cyc[1] == c + 3, "R1", log_cyc[1], c + 3);
        end
        if (n_irq >= 1) chk(irq_cyc[0] == c + 4, "R7", irq_cyc[0], c + 4);
        check_records(1, "R2");
    endtask

    // R3, R4: each non-message type on its own
    task automatic t_nonmsg();
        clr_log();
        @(negedge clk); ram_par_evt = 1'b1; ram_par_addr = 16'h0ABC;
        @(negedge clk); ram_par_evt = 1'b0; idle(4);
        @(negedge clk); rt_par_evt = 1'b1;
        @(negedge clk); rt_par_evt = 1'b0; idle(4);
        @(negedge clk); tt_roll_evt = 1'b1;
        @(negedge clk); tt_roll_evt = 1'b0; idle(4);
        @(negedge clk); bist_done_evt = 1'b1;
        @(negedge clk); bist_done_evt = 1'b0; idle(6);
        exp_vec[0] = 16'h0002; exp_par[0] = 16'h0ABC;
        exp_vec[1] = 16'h0004; exp_par[1] = 16'h0000;
        exp_vec[2] = 16'h0008; exp_par[2] = 16'h0000;
        exp_vec[3] = 16'h0010; exp_par[3] = 16'h0000;
        check_records(4, "R3/R4");
    endtask

    // R5, R9: all five events in one cycle come out in priority order, back to back
    task automatic t_priority();
        int c;
        clr_log();
        @(negedge clk);
        ram_par_evt = 1'b1; ram_par_addr = 16'h00F0; rt_par_evt = 1'b1; tt_roll_evt = 1'b1;
        bist_done_evt = 1'b1; msg_evt = 1'b1; msg_evt_ptr = 16'h4321; msg_evt_status = 11'h001;
        c = cyc;
        @(negedge clk);
        ram_par_evt = 1'b0; rt_par_evt = 1'b0; tt_roll_evt = 1'b0; bist_done_evt = 1'b0; msg_evt = 1'b0;
        idle(14);
        exp_vec[0] = 16'h0002; exp_par[0] = 16'h00F0;
        exp_vec[1] = 16'h0004; exp_par[1] = 16'h0000;
        exp_vec[2] = 16'h0008; exp_par[2] = 16'h0000;
        exp_vec[3] = 16'h0010; exp_par[3] = 16'h0000;
        exp_vec[4] = 16'h0021; exp_par[4] = 16'h4321;
        if (n_log == 10) chk(log_cyc[9] == c + 11, "R9", log_cyc[9], c + 11);
        check_records(5, "R5");
    endtask

    // R11: a second RAM parity event while the first is pending is merged
    task automatic t_merge();
        clr_log();
        @(negedge clk); rt_par_evt = 1'b1;
        @(negedge clk); rt_par_evt = 1'b0; ram_par_evt = 1'b1; ram_par_addr = 16'h0111;
        @(negedge clk); ram_par_addr = 16'h0222;
        @(negedge clk); ram_par_evt = 1'b0;
        idle(8);
        exp_vec[0] = 16'h0004; exp_par[0] = 16'h0000;
        exp_vec[1] = 16'h0002; exp_par[1] = 16'h0111;
        check_records(2, "R11");
    endtask

    // R10: events are dropped while the queue is disabled
    task automatic t_disable();
        clr_log();
        queue_en = 1'b0;
        @(negedge clk);
        ram_par_evt = 1'b1; rt_par_evt = 1'b1; tt_roll_evt = 1'b1; bist_done_evt = 1'b1; msg_evt = 1'b1;
        @(negedge clk);
        ram_par_evt = 1'b0; rt_par_evt = 1'b0; tt_roll_evt = 1'b0; bist_done_evt = 1'b0; msg_evt = 1'b0;
        idle(4);
        queue_en = 1'b1;
        idle(8);
        chk(n_log == 0, "R10", n_log, 0);
        chk(queue_ptr == (REGION | 16'(exp_idx)), "R10", queue_ptr, REGION | 16'(exp_idx));
    endtask

    // R8: one full lap with rollover enabled, then a lap with it disabled
    task automatic t_wrap();
        int k;
        for (int lap = 0; lap < 2; lap++) begin
            clr_log();
            rollover_en = (lap == 0);
            k = ((62 - exp_idx + 64) % 64) / 2;
            for (int i = 0; i < 32; i++) begin
                @(negedge clk); msg_evt = 1'b1; msg_evt_ptr = 16'(i);
                @(negedge clk); msg_evt = 1'b0;
                idle(2);
            end
            idle(6);
            chk(n_irq == 32, "R7", n_irq, 32);
            chk(queue_ptr == (REGION | 16'(exp_idx)), "R6", queue_ptr, REGION | 16'(exp_idx));
            if (lap == 0) begin
                chk(n_roll == 1, "R8", n_roll, 1);
                if (n_roll >= 1 && n_irq > k) chk(roll_cyc[0] == irq_cyc[k], "R8", roll_cyc[0], irq_cyc[k]);
            end else begin
                chk(n_roll == 0, "R8", n_roll, 0);
            end
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        queue_en = 1'b1;
        t_reset();
        t_message();
        t_nonmsg();
        t_priority();
        t_merge();
        t_disable();
        t_wrap();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule